// File: doc/BRIEF.md
# Shared-Memory Wavetable Voice Mixer

This block plays several wavetable voices from one sample memory. Each output sample period is split into clock slots. The first slots each belong to one voice. In its slot a voice forms a read address from its phase accumulator and reads one sample from the shared memory. That sample, weighted by the voice's volume, is then added into a wide mix sum. The phase then advances by the voice's increment. Any slots left in the period are idle. At the end of the period the sum is scaled, clamped to 16-bit signed and presented once on the DAC output with a strobe. With a 50 MHz clock and the default period of 1042 cycles, the sample rate is close to 48 kHz.

A voice can take another voice's most recent sample as a phase modulator. When this is enabled, the modulator's sample from the previous period is sign-extended and shifted left by a programmable amount. The result is added to the carrier's phase only when the read address is formed. The carrier's stored phase is never altered by this offset. Software fills the sample memory through a write port and sets each voice's registers through a small write interface.

Top module: `synth_voice_mixer`

## Requirements
- R1: `dac_strobe` is high for exactly one cycle, once every PERIOD clock cycles. `dac_data` changes only in the cycle the strobe rises.
- R2: Once per period, each voice's 24-bit phase grows by its increment, wrapping modulo 2^24. The voice reads the memory word addressed by phase bits [23:16].
- R3: The output is floor(sum over voices of sample × volume / 256). Samples are 16-bit two's complement and volume is an unsigned 8-bit value. The sum never overflows inside the block.
- R4: The result is clamped to the range from -32768 to 32767 before it reaches `dac_data`.
- R5: With modulation enabled, the read address uses phase + (sign-extended modulator sample from the previous period shifted left by the shift field), modulo 2^24. The stored phase still advances only by the increment, so turning modulation off resumes the unmodulated track.
- R6: A write with `cfg_we` high updates the field of voice `cfg_voice` that `cfg_sel` selects. The codes are: 0 sets the increment from `cfg_data[23:0]`, 1 sets the volume from `cfg_data[7:0]`, and 3 sets the phase from `cfg_data[23:0]`. Code 2 sets the modulation controls: bit 0 is the enable, bits [3:1] are the source voice and bits [6:4] are the shift.
- R7: A write with `ram_we` high stores `ram_wdata` at `ram_addr`. A voice that reads that address in a later period uses the new word.
- R8: After reset every voice register is zero, `dac_strobe` is low and `dac_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Voice register write enable |
| cfg_voice | input | 3 | Voice selected for the write |
| cfg_sel | input | 2 | Field selected for the write |
| cfg_data | input | 24 | Write data |
| ram_we | input | 1 | Sample memory write enable |
| ram_addr | input | 8 | Sample memory write address |
| ram_wdata | input | 16 | Sample memory write data |
| dac_data | output | 16 | Mixed, clamped output word |
| dac_strobe | output | 1 | One-cycle pulse marking a new output word |

## Verification
The situation hardest to reach from the ports is a frequency-modulated carrier whose modulator history is fully known. It is followed by proof that the carrier's stored phase was never disturbed. To reach it, the bench discards the first period after reprogramming, because that period's snapshot still holds old samples. It then checks modulated periods, clears only the enable bit in an idle window, and checks that later outputs follow the pure increment track. Every register write is placed in the idle slots after the voice slots, counted from the strobe. This ensures each period starts from a state the bench's own model knows exactly.

// File: rtl/synth_mix_pkg.sv
package synth_mix_pkg;

    typedef enum logic [1:0] {
        SEL_INC   = 2'd0,
        SEL_VOL   = 2'd1,
        SEL_FM    = 2'd2,
        SEL_PHASE = 2'd3
    } cfg_sel_e;

endpackage

// File: rtl/synth_sample_ram.sv
module synth_sample_ram #(
    parameter int ADDR_W   = 8,
    parameter int SAMPLE_W = 16,
    localparam int DEPTH   = 1 << ADDR_W
) (
    input  logic                clk,
    input  logic                we,
    input  logic [ADDR_W-1:0]   waddr,
    input  logic [SAMPLE_W-1:0] wdata,
    input  logic [ADDR_W-1:0]   raddr,
    output logic [SAMPLE_W-1:0] rdata
);

    logic [SAMPLE_W-1:0] mem [DEPTH];
    logic [SAMPLE_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata_q <= mem[raddr];
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/synth_voice_regs.sv
module synth_voice_regs
    import synth_mix_pkg::*;
#(
    parameter int NUM_VOICES = 8,
    parameter int PHASE_W    = 24,
    parameter int ADDR_W     = 8,
    parameter int SAMPLE_W   = 16,
    parameter int VOL_W      = 8,
    parameter int SHIFT_W    = 3,
    localparam int IDX_W     = $clog2(NUM_VOICES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [IDX_W-1:0]    cfg_voice,
    input  logic [1:0]          cfg_sel,
    input  logic [PHASE_W-1:0]  cfg_data,
    input  logic                slot_valid,
    input  logic [IDX_W-1:0]    slot_idx,
    input  logic                cap_valid,
    input  logic [IDX_W-1:0]    cap_idx,
    input  logic [SAMPLE_W-1:0] cap_sample,
    input  logic                period_end,
    output logic [ADDR_W-1:0]   rd_addr,
    output logic [VOL_W-1:0]    cap_vol
);

    typedef struct packed {
        logic [NUM_VOICES-1:0][PHASE_W-1:0]  phase;
        logic [NUM_VOICES-1:0][PHASE_W-1:0]  inc;
        logic [NUM_VOICES-1:0][VOL_W-1:0]    vol;
        logic [NUM_VOICES-1:0]               fm_en;
        logic [NUM_VOICES-1:0][IDX_W-1:0]    fm_src;
        logic [NUM_VOICES-1:0][SHIFT_W-1:0]  fm_sh;
        logic [NUM_VOICES-1:0][SAMPLE_W-1:0] cur;
        logic [NUM_VOICES-1:0][SAMPLE_W-1:0] mods;
    } vregs_t;

    vregs_t q, d;

    // next-state: phase step, sample capture, period snapshot, software writes
    always_comb begin
        d = q;
        if (slot_valid) begin
            d.phase[slot_idx] = q.phase[slot_idx] + q.inc[slot_idx];
        end
        if (cap_valid) begin
            d.cur[cap_idx] = cap_sample;
        end
        if (period_end) begin
            d.mods = q.cur;
        end
        if (cfg_we) begin
            case (cfg_sel_e'(cfg_sel))
                SEL_INC:   d.inc[cfg_voice]   = cfg_data;
                SEL_VOL:   d.vol[cfg_voice]   = cfg_data[VOL_W-1:0];
                SEL_FM: begin
                    d.fm_en[cfg_voice]  = cfg_data[0];
                    d.fm_src[cfg_voice] = cfg_data[IDX_W:1];
                    d.fm_sh[cfg_voice]  = cfg_data[IDX_W+SHIFT_W:IDX_W+1];
                end
                SEL_PHASE: d.phase[cfg_voice] = cfg_data;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    // read address: stored phase plus optional modulation offset
    logic [SAMPLE_W-1:0] mod_s;
    logic [PHASE_W-1:0]  fm_off;
    logic [PHASE_W-1:0]  eff_phase;

    always_comb begin
        mod_s  = q.mods[q.fm_src[slot_idx]];
        fm_off = '0;
        if (q.fm_en[slot_idx]) begin
            fm_off = {{(PHASE_W-SAMPLE_W){mod_s[SAMPLE_W-1]}}, mod_s} << q.fm_sh[slot_idx];
        end
        eff_phase = q.phase[slot_idx] + fm_off;
    end

    assign rd_addr = eff_phase[PHASE_W-1 -: ADDR_W];
    assign cap_vol = q.vol[cap_idx];

    AST_IDLE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        (!slot_valid && !cfg_we) |=> $stable(q.phase)); // R2

    AST_FM_PHASE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_valid && q.fm_en[slot_idx] && !cfg_we)
        |=> (q.phase[$past(slot_idx)] - $past(q.phase[slot_idx])) == $past(q.inc[slot_idx])); // R5

endmodule

// File: rtl/synth_mix_accum.sv
module synth_mix_accum #(
    parameter int NUM_VOICES = 8,
    parameter int SAMPLE_W   = 16,
    parameter int VOL_W      = 8,
    localparam int IDX_W     = $clog2(NUM_VOICES),
    localparam int PROD_W    = SAMPLE_W + VOL_W + 1,
    localparam int ACC_W     = PROD_W + IDX_W,
    localparam int SC_W      = ACC_W - VOL_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cap_valid,
    input  logic [SAMPLE_W-1:0] cap_sample,
    input  logic [VOL_W-1:0]    cap_vol,
    input  logic                period_end,
    output logic [SAMPLE_W-1:0] dac_data,
    output logic                dac_strobe
);

    localparam logic [SC_W-1:0] SAT_HI = {{(SC_W-SAMPLE_W+1){1'b0}}, {(SAMPLE_W-1){1'b1}}};
    localparam logic [SC_W-1:0] SAT_LO = ~SAT_HI;

    typedef struct packed {
        logic [ACC_W-1:0]    acc;
        logic [SAMPLE_W-1:0] out;
        logic                strobe;
    } mix_t;

    mix_t q, d;

    logic signed [PROD_W-1:0] prod;
    logic [ACC_W-1:0]         prod_ext;
    logic [SC_W-1:0]          scaled;

    assign prod     = $signed(cap_sample) * $signed({1'b0, cap_vol});
    assign prod_ext = {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};
    assign scaled   = q.acc[ACC_W-1:VOL_W];

    always_comb begin
        d        = q;
        d.strobe = 1'b0;
        if (period_end) begin
            d.acc    = '0;
            d.strobe = 1'b1;
            if ($signed(scaled) > $signed(SAT_HI)) begin
                d.out = SAT_HI[SAMPLE_W-1:0];
            end else if ($signed(scaled) < $signed(SAT_LO)) begin
                d.out = SAT_LO[SAMPLE_W-1:0];
            end else begin
                d.out = scaled[SAMPLE_W-1:0];
            end
        end else if (cap_valid) begin
            d.acc = q.acc + prod_ext;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign dac_data   = q.out;
    assign dac_strobe = q.strobe;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        q.acc[ACC_W-1] == q.acc[ACC_W-2]); // R3

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !period_end |=> $stable(dac_data)); // R1

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        dac_strobe |=> !dac_strobe); // R1

    AST_SAT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (period_end && $signed(scaled) > $signed(SAT_HI)) |=> dac_data == SAT_HI[SAMPLE_W-1:0]); // R4

endmodule

// File: rtl/synth_voice_mixer.sv
module synth_voice_mixer #(
    parameter int NUM_VOICES = 8,
    parameter int PHASE_W    = 24,
    parameter int ADDR_W     = 8,
    parameter int SAMPLE_W   = 16,
    parameter int VOL_W      = 8,
    parameter int SHIFT_W    = 3,
    parameter int PERIOD     = 1042,
    localparam int IDX_W     = $clog2(NUM_VOICES),
    localparam int CNT_W     = $clog2(PERIOD)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [IDX_W-1:0]    cfg_voice,
    input  logic [1:0]          cfg_sel,
    input  logic [PHASE_W-1:0]  cfg_data,
    input  logic                ram_we,
    input  logic [ADDR_W-1:0]   ram_addr,
    input  logic [SAMPLE_W-1:0] ram_wdata,
    output logic [SAMPLE_W-1:0] dac_data,
    output logic                dac_strobe
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             cap_valid;
        logic [IDX_W-1:0] cap_idx;
    } seq_t;

    seq_t q, d;

    logic                slot_valid;
    logic [IDX_W-1:0]    slot_idx;
    logic                period_end;
    logic [ADDR_W-1:0]   rd_addr;
    logic [SAMPLE_W-1:0] rd_data;
    logic [VOL_W-1:0]    cap_vol;

    assign slot_valid = q.cnt < CNT_W'(NUM_VOICES);
    assign slot_idx   = q.cnt[IDX_W-1:0];
    assign period_end = q.cnt == CNT_W'(PERIOD - 1);

    always_comb begin
        d           = q;
        d.cnt       = period_end ? '0 : q.cnt + 1'b1;
        d.cap_valid = slot_valid;
        d.cap_idx   = slot_idx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    synth_sample_ram #(
        .ADDR_W   (ADDR_W),
        .SAMPLE_W (SAMPLE_W)
    ) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (ram_addr),
        .wdata (ram_wdata),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    synth_voice_regs #(
        .NUM_VOICES (NUM_VOICES),
        .PHASE_W    (PHASE_W),
        .ADDR_W     (ADDR_W),
        .SAMPLE_W   (SAMPLE_W),
        .VOL_W      (VOL_W),
        .SHIFT_W    (SHIFT_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_voice  (cfg_voice),
        .cfg_sel    (cfg_sel),
        .cfg_data   (cfg_data),
        .slot_valid (slot_valid),
        .slot_idx   (slot_idx),
        .cap_valid  (q.cap_valid),
        .cap_idx    (q.cap_idx),
        .cap_sample (rd_data),
        .period_end (period_end),
        .rd_addr    (rd_addr),
        .cap_vol    (cap_vol)
    );

    synth_mix_accum #(
        .NUM_VOICES (NUM_VOICES),
        .SAMPLE_W   (SAMPLE_W),
        .VOL_W      (VOL_W)
    ) u_mix (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_valid  (q.cap_valid),
        .cap_sample (rd_data),
        .cap_vol    (cap_vol),
        .period_end (period_end),
        .dac_data   (dac_data),
        .dac_strobe (dac_strobe)
    );

    AST_STROBE_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        dac_strobe |-> q.cnt == '0); // R1

    AST_CAPTURE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        q.cap_valid |-> $past(slot_valid)); // R2

endmodule

// File: tb/tb_synth_voice_mixer.sv
module tb_synth_voice_mixer;

    localparam int NV     = 8;
    localparam int PERIOD = 64;
    localparam int PMASK  = 32'h00FF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_voice = '0;
    logic [1:0]  cfg_sel = '0;
    logic [23:0] cfg_data = '0;
    logic        ram_we = 1'b0;
    logic [7:0]  ram_addr = '0;
    logic [15:0] ram_wdata = '0;
    logic [15:0] dac_data;
    logic        dac_strobe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int m_mem [256];
    int m_ph [NV];
    int m_inc [NV];
    int m_vol [NV];
    int m_fen [NV];
    int m_fsrc [NV];
    int m_fsh [NV];
    int m_cur [NV];
    int m_mod [NV];

    always #10 clk = ~clk;

    synth_voice_mixer #(.PERIOD(PERIOD)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_voice(cfg_voice),
        .cfg_sel(cfg_sel), .cfg_data(cfg_data), .ram_we(ram_we),
        .ram_addr(ram_addr), .ram_wdata(ram_wdata),
        .dac_data(dac_data), .dac_strobe(dac_strobe)
    );

    task automatic chk(input string req, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    function automatic int sample_init(input int a);
        int v;
        v = ((a ^ 8'h80) << 8) | ((a * 37) & 255);
        if (v >= 32768) v -= 65536;
        return v;
    endfunction

    task automatic clear_model();
        for (int v = 0; v < NV; v++) begin
            m_ph[v] = 0; m_inc[v] = 0; m_vol[v] = 0;
            m_fen[v] = 0; m_fsrc[v] = 0; m_fsh[v] = 0;
            m_cur[v] = 0; m_mod[v] = 0;
        end
    endtask

    task automatic model_period(output int expv);
        int acc;
        acc = 0;
        for (int v = 0; v < NV; v++) begin
            int off;
            int eff;
            off = 0;
            if (m_fen[v] != 0) off = m_mod[m_fsrc[v]] * (1 << m_fsh[v]);
            eff = (m_ph[v] + off) & PMASK;
            m_cur[v] = m_mem[eff >> 16];
            acc += m_cur[v] * m_vol[v];
            m_ph[v] = (m_ph[v] + m_inc[v]) & PMASK;
        end
        for (int v = 0; v < NV; v++) m_mod[v] = m_cur[v];
        expv = acc >>> 8;
        if (expv > 32767) expv = 32767;
        if (expv < -32768) expv = -32768;
    endtask

    task automatic wait_strobe();
        do @(negedge clk); while (!dac_strobe);
    endtask

    task automatic cfg_wr(input int v, input int sel, input int data);
        cfg_we = 1'b1;
        cfg_voice = v[2:0];
        cfg_sel = sel[1:0];
        cfg_data = data[23:0];
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic ram_wr(input int a, input int data);
        ram_we = 1'b1;
        ram_addr = a[7:0];
        ram_wdata = data[15:0];
        @(negedge clk);
        ram_we = 1'b0;
    endtask

    // writes land in the idle slots of one period; that period is then skipped
    task automatic apply_config();
        wait_strobe();
        repeat (NV + 2) @(negedge clk);
        for (int v = 0; v < NV; v++) begin
            cfg_wr(v, 0, m_inc[v]);
            cfg_wr(v, 1, m_vol[v]);
            cfg_wr(v, 2, m_fen[v] | (m_fsrc[v] << 1) | (m_fsh[v] << 4));
            cfg_wr(v, 3, m_ph[v]);
        end
        wait_strobe();
    endtask

    task automatic run_periods(input int n, input bit skip_first, input string req);
        for (int k = 0; k < n; k++) begin
            int expv;
            model_period(expv);
            wait_strobe();
            if (!(skip_first && k == 0)) chk(req, int'($signed(dac_data)), expv);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int expv;
        int cnt;
        clear_model();
        for (int a = 0; a < 256; a++) m_mem[a] = sample_init(a);

        // R8: reset state
        repeat (3) @(negedge clk);
        chk("R8 strobe in reset", int'(dac_strobe), 0);
        chk("R8 data in reset", int'(dac_data), 0);
        rst_n = 1'b1;
        for (int a = 0; a < 256; a++) ram_wr(a, m_mem[a]);

        // R1: strobe spacing and width
        wait_strobe();
        chk("R8 silent after reset", int'($signed(dac_data)), 0);
        cnt = 0;
        @(negedge clk);
        cnt++;
        chk("R1 strobe width", int'(dac_strobe), 0);
        while (!dac_strobe) begin
            @(negedge clk);
            cnt++;
        end
        chk("R1 strobe spacing", cnt, PERIOD);

        // R2 R3 R7: single voice, one address per period, several volumes
        for (int vi = 0; vi < 5; vi++) begin
            int vols [5] = '{255, 128, 1, 0, 77};
            clear_model();
            m_vol[0] = vols[vi];
            m_inc[0] = 32'h010000;
            m_ph[0] = (vi * 40) << 16;
            apply_config();
            run_periods(8, 1'b0, "R3 single voice");
        end

        // R2: fractional step with phase wraparound on voice 3
        clear_model();
        m_vol[3] = 200;
        m_inc[3] = 32'h00C000;
        m_ph[3] = 32'hFF8000;
        apply_config();
        run_periods(10, 1'b0, "R2 fractional wrap");

        // R3: all voices active with distinct settings
        clear_model();
        for (int v = 0; v < NV; v++) begin
            m_vol[v] = 20 + v * 13;
            m_inc[v] = v * 32'h3100 + 32'h1234;
            m_ph[v] = (v * 32'h1F0000) & PMASK;
        end
        apply_config();
        run_periods(16, 1'b0, "R3 eight voices");

        // R4: clamp high, just under the limit, clamp low
        clear_model();
        for (int v = 0; v < NV; v++) begin m_vol[v] = 255; m_ph[v] = 32'hFF0000; end
        apply_config();
        run_periods(2, 1'b0, "R4 clamp high");
        chk("R4 clamp high value", int'($signed(dac_data)), 32767);
        clear_model();
        m_vol[2] = 128; m_ph[2] = 32'hFF0000;
        m_vol[5] = 128; m_ph[5] = 32'hFF0000;
        apply_config();
        run_periods(2, 1'b0, "R4 below limit");
        clear_model();
        for (int v = 0; v < NV; v++) begin m_vol[v] = 255; m_ph[v] = 0; end
        apply_config();
        run_periods(2, 1'b0, "R4 clamp low");
        chk("R4 clamp low value", int'($signed(dac_data)), -32768);

        // R5 R6: modulation, carrier after and before its source
        clear_model();
        m_inc[0] = 32'h030000;
        m_vol[1] = 200; m_inc[1] = 32'h008000;
        m_fen[1] = 1; m_fsrc[1] = 0; m_fsh[1] = 3;
        apply_config();
        run_periods(12, 1'b1, "R5 fm shift 3");
        clear_model();
        m_inc[5] = 32'h050000; m_ph[5] = 32'h120000;
        m_vol[6] = 180; m_inc[6] = 32'h004000;
        m_fen[6] = 1; m_fsrc[6] = 5; m_fsh[6] = 7;
        m_vol[2] = 90; m_inc[2] = 32'h010000;
        m_fen[2] = 1; m_fsrc[2] = 5; m_fsh[2] = 5;
        apply_config();
        run_periods(12, 1'b1, "R6 fm src and shift fields");

        // R5: disable modulation mid-run; stored phase must be unaffected
        model_period(expv);
        repeat (NV + 2) @(negedge clk);
        cfg_wr(6, 2, 0);
        cfg_wr(2, 2, 0);
        wait_strobe();
        chk("R5 last modulated period", int'($signed(dac_data)), expv);
        m_fen[6] = 0;
        m_fen[2] = 0;
        run_periods(8, 1'b0, "R5 phase kept after fm off");

        // R7: rewrite a memory word while a voice reads it
        clear_model();
        m_vol[4] = 255; m_ph[4] = 32'h400000;
        apply_config();
        run_periods(2, 1'b0, "R7 before rewrite");
        model_period(expv);
        repeat (NV + 2) @(negedge clk);
        ram_wr(8'h40, 16'h1234);
        m_mem[8'h40] = 32'h1234;
        wait_strobe();
        chk("R7 period before rewrite", int'($signed(dac_data)), expv);
        run_periods(2, 1'b0, "R7 after rewrite");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule